// File: doc/BRIEF.md
# Random Word Conditioner

This block turns a stream of single noise bits into 32-bit random words. Each bit from the noise source, or from an internal repeatable generator when test mode is on, passes through an optional conditioning chain before it is packed into a word. The chain has two stages: a scrambling LFSR that folds each bit into its state, and a pair-based bias corrector. A two-bit select picks which stages are in the path.

Once 32 conditioned bits have been packed, the ready flag goes high and the word is held. A read strobe consumes it and accumulation of the next word begins. While a word waits to be read, the whole chain is frozen. Noise bits offered during that time are lost, and the held word is never overwritten.

The packer is a two-state machine. In FILL it shifts accepted bits into the word. It moves to HOLD on the 32nd accepted bit. In HOLD it waits for a read strobe and then returns to FILL. The bias corrector is also a two-state machine. EMPTY means no first bit of a pair is stored; an accepted bit moves it to HALF. HALF means the first bit of a pair is held; the second bit returns it to EMPTY, whether or not an output bit is emitted. When its stage is deselected, the corrector stays in its current state.

Top module: `rng_postproc`

## Requirements
- R1: After reset, `word_ready` is 0 and `rand_word` is 0.
- R2: `pp_sel` chooses the path. Value 0 passes bits straight through. Value 1 uses the scrambling LFSR only. Value 2 uses the bias corrector only. Value 3 feeds the LFSR output into the bias corrector.
- R3: The scrambling LFSR starts at 0 after reset. For each accepted bit b, with state s, the output is f = s[0] XOR b. The new state is (s >> 1), XORed with 32'h8020_0003 when f is 1.
- R4: The bias corrector takes bits in pairs. A pair 0 then 1 emits 0. A pair 1 then 0 emits 1. Pairs 00 and 11 emit nothing.
- R5: While `noise_en` is 0, no bit is accepted. `rand_word` keeps its value and the test generator does not advance.
- R6: With `test_en` 0, one noise bit is accepted in each cycle in which `noise_stb` is 1. With `test_en` 1, one generator bit is accepted every cycle, and `noise_bit` and `noise_stb` have no effect.
- R7: The test generator starts at 32'hACE1_2468 after reset. Its output is its low bit. Each use steps it from s to (s >> 1), XORed with 32'h8020_0003 when s[0] is 1. The word sequence after reset is therefore repeatable.
- R8: The first packed bit ends in bit 31 and the last in bit 0. `word_ready` rises in the cycle after the 32nd packed bit. In test mode with `pp_sel` 0 or 1, that is 32 cycles after accepting begins.
- R9: A `data_rd` pulse while `word_ready` is 1 clears `word_ready` in the next cycle and starts a new word. A `data_rd` pulse while `word_ready` is 0 has no effect.
- R10: While `word_ready` is 1 and no read arrives, `rand_word` is stable and offered bits are dropped. No conditioning stage or generator advances, so the next word continues the sequence exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| noise_bit | input | 1 | Bit from the noise source |
| noise_stb | input | 1 | Qualifies `noise_bit` for one cycle |
| noise_en | input | 1 | Allows bits to be accepted |
| test_en | input | 1 | Uses the internal repeatable generator instead of noise |
| pp_sel | input | 2 | Conditioning path select |
| data_rd | input | 1 | Read strobe for the data word |
| rand_word | output | 32 | Data word |
| word_ready | output | 1 | Status flag: a complete word is held |

## Verification
A corrupted state in any stage shows up in the next completed word, within 32 accepted bits in the bypass and LFSR paths. In test mode the whole word sequence is fixed after reset, so a single wrong bit in the generator, the scrambler or the corrector's half-pair register changes the next word compared against the bench's model. A packer counter that is off by one moves the rise of `word_ready` away from cycle 32. A chain that advances while a word is held shows up as a skipped section in the word read after the hold.

// File: rtl/rngpp_pkg.sv
package rngpp_pkg;

    // Conditioning path select; bit 0 enables the LFSR stage, bit 1 the corrector.
    typedef enum logic [1:0] {
        PP_RAW   = 2'd0,
        PP_LFSR  = 2'd1,
        PP_WHITE = 2'd2,
        PP_BOTH  = 2'd3
    } pp_mode_e;

    typedef enum logic {
        ACC_FILL = 1'b0,
        ACC_HOLD = 1'b1
    } acc_state_e;

    typedef enum logic {
        WH_EMPTY = 1'b0,
        WH_HALF  = 1'b1
    } wh_state_e;

    // Galois mask for x^32 + x^22 + x^2 + x + 1 (right-shifting form).
    localparam logic [31:0] GALOIS_MASK32 = 32'h8020_0003;

endpackage

// File: rtl/rngpp_source.sv
module rngpp_source #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = W'(32'hACE1_2468),
    parameter logic [W-1:0] MASK = W'(32'h8020_0003)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic noise_bit,
    input  logic noise_stb,
    input  logic noise_en,
    input  logic test_en,
    input  logic accept,
    output logic src_bit,
    output logic src_valid
);

    logic [W-1:0] gen_q;

    always_comb begin
        src_valid = noise_en && accept && (test_en || noise_stb);
        src_bit   = test_en ? gen_q[0] : noise_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= SEED;
        end else if (src_valid && test_en) begin
            gen_q <= (gen_q >> 1) ^ (gen_q[0] ? MASK : '0);
        end
    end

    // R7: the repeatable generator never collapses to the all-zero state
    a_r7_gen_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q != '0);

    // R5: with the source disabled the generator holds its state
    a_r5_gen_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_en |=> $stable(gen_q));

endmodule

// File: rtl/rngpp_lfsr_stage.sv
module rngpp_lfsr_stage #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = W'(32'h8020_0003)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit
);

    logic [W-1:0] st_q;
    logic         fold;

    always_comb begin
        fold      = st_q[0] ^ in_bit;
        out_valid = in_valid;
        out_bit   = enable ? fold : in_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (enable && in_valid) begin
            st_q <= (st_q >> 1) ^ (fold ? MASK : '0);
        end
    end

    // R2: a deselected scrambler keeps its state
    a_r2_lfsr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(st_q));

endmodule

// File: rtl/rngpp_whitener.sv
module rngpp_whitener
    import rngpp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit
);

    wh_state_e st_q, st_d;
    logic      first_q;

    // next state
    always_comb begin
        st_d = st_q;
        if (enable && in_valid) begin
            unique case (st_q)
                WH_EMPTY: st_d = WH_HALF;
                WH_HALF:  st_d = WH_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_bit   = in_bit;
        if (!enable) begin
            out_valid = in_valid;
        end else begin
            unique case (st_q)
                WH_EMPTY: out_valid = 1'b0;
                WH_HALF: begin
                    out_valid = in_valid && (first_q != in_bit);
                    out_bit   = first_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= WH_EMPTY;
            first_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (enable && in_valid && st_q == WH_EMPTY) begin
                first_q <= in_bit;
            end
        end
    end

    // R4: an emitted bit always closes the pair
    a_r4_pair_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && out_valid) |=> st_q == WH_EMPTY);

endmodule

// File: rtl/rngpp_accum.sv
module rngpp_accum
    import rngpp_pkg::*;
#(
    parameter int W = 32,
    localparam int CNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_bit,
    input  logic         data_rd,
    output logic         ready,
    output logic [W-1:0] word,
    output logic         valid
);

    acc_state_e     st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     word_q;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_FILL: if (in_valid && cnt_q == CNT_W'(W-1)) st_d = ACC_HOLD;
            ACC_HOLD: if (data_rd) st_d = ACC_FILL;
        endcase
    end

    // outputs
    always_comb begin
        ready = (st_q == ACC_FILL);
        valid = (st_q == ACC_HOLD);
        word  = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ACC_FILL;
            cnt_q  <= '0;
            word_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ACC_FILL && in_valid) begin
                word_q <= {word_q[W-2:0], in_bit};
                cnt_q  <= (cnt_q == CNT_W'(W-1)) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // R9: a read of a held word clears the flag
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && data_rd) |=> !valid);

    // R10: an unread word stays put
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !data_rd) |=> (valid && $stable(word_q)));

    // R10: upstream offers nothing while a word is held
    a_r10_no_bit_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ready);

endmodule

// File: rtl/rng_postproc.sv
module rng_postproc
    import rngpp_pkg::*;
#(
    parameter int           WORD_W   = 32,
    parameter logic [31:0]  GEN_SEED = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              noise_bit,
    input  logic              noise_stb,
    input  logic              noise_en,
    input  logic              test_en,
    input  logic [1:0]        pp_sel,
    input  logic              data_rd,
    output logic [WORD_W-1:0] rand_word,
    output logic              word_ready
);

    localparam int LFSR_W = 32;

    logic     accept;
    logic     src_bit, src_valid;
    logic     scr_bit, scr_valid;
    logic     wh_bit, wh_valid;
    pp_mode_e mode;
    logic     lfsr_on, white_on;

    always_comb begin
        mode     = pp_mode_e'(pp_sel);
        lfsr_on  = (mode == PP_LFSR)  || (mode == PP_BOTH);
        white_on = (mode == PP_WHITE) || (mode == PP_BOTH);
    end

    rngpp_source #(
        .W    (LFSR_W),
        .SEED (GEN_SEED),
        .MASK (GALOIS_MASK32)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .noise_bit (noise_bit),
        .noise_stb (noise_stb),
        .noise_en  (noise_en),
        .test_en   (test_en),
        .accept    (accept),
        .src_bit   (src_bit),
        .src_valid (src_valid)
    );

    rngpp_lfsr_stage #(
        .W    (LFSR_W),
        .MASK (GALOIS_MASK32)
    ) u_scr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (lfsr_on),
        .in_valid  (src_valid),
        .in_bit    (src_bit),
        .out_valid (scr_valid),
        .out_bit   (scr_bit)
    );

    rngpp_whitener u_wh (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (white_on),
        .in_valid  (scr_valid),
        .in_bit    (scr_bit),
        .out_valid (wh_valid),
        .out_bit   (wh_bit)
    );

    rngpp_accum #(
        .W (WORD_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (wh_valid),
        .in_bit   (wh_bit),
        .data_rd  (data_rd),
        .ready    (accept),
        .word     (rand_word),
        .valid    (word_ready)
    );

    // R5: with the source disabled the data word cannot change
    a_r5_gate_word: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_en |=> $stable(rand_word));

endmodule

// File: tb/tb_rng_postproc.sv
`timescale 1ns/1ps
module tb_rng_postproc;

    localparam logic [31:0] MASK = 32'h8020_0003;
    localparam logic [31:0] SEED = 32'hACE1_2468;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        noise_bit = 1'b0;
    logic        noise_stb = 1'b0;
    logic        noise_en = 1'b0;
    logic        test_en = 1'b0;
    logic [1:0]  pp_sel = 2'd0;
    logic        data_rd = 1'b0;
    logic [31:0] rand_word;
    logic        word_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    logic [31:0] m_gen, m_scr;
    logic        m_have, m_first;

    always #2 clk = ~clk;

    rng_postproc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .noise_bit  (noise_bit),
        .noise_stb  (noise_stb),
        .noise_en   (noise_en),
        .test_en    (test_en),
        .pp_sel     (pp_sel),
        .data_rd    (data_rd),
        .rand_word  (rand_word),
        .word_ready (word_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; noise_en = 1'b0; test_en = 1'b0; noise_stb = 1'b0;
        data_rd = 1'b0; pp_sel = 2'd0; noise_bit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_gen = SEED; m_scr = '0; m_have = 1'b0; m_first = 1'b0;
    endtask

    // Next expected test-mode word from the requirement definitions (R2,R3,R4,R7,R8)
    task automatic model_word(input logic [1:0] sel, output logic [31:0] w);
        int n;
        logic b, f, ok;
        n = 0;
        w = '0;
        while (n < 32) begin
            b = m_gen[0];
            m_gen = (m_gen >> 1) ^ (m_gen[0] ? MASK : 32'h0);
            ok = 1'b1;
            if (sel[0]) begin
                f = m_scr[0] ^ b;
                m_scr = (m_scr >> 1) ^ (f ? MASK : 32'h0);
                b = f;
            end
            if (sel[1]) begin
                if (!m_have) begin
                    m_have = 1'b1; m_first = b; ok = 1'b0;
                end else begin
                    m_have = 1'b0;
                    ok = (m_first != b);
                    b = m_first;
                end
            end
            if (ok) begin
                w = {w[30:0], b};
                n++;
            end
        end
    endtask

    task automatic wait_ready(input int limit, output int cycles);
        cycles = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (word_ready) begin
                cycles = i;
                break;
            end
        end
    endtask

    task automatic read_word();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic push_bit(input logic b);
        noise_bit = b; noise_stb = 1'b1;
        @(negedge clk);
        noise_stb = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        chk(word_ready == 1'b0, "R1 ready after reset", 32'(word_ready), 32'h0);
        chk(rand_word == 32'h0, "R1 word after reset", rand_word, 32'h0);
    endtask

    // R5, R7, R8, R6 ignored noise in test mode
    task automatic t_test_raw();
        logic [31:0] e;
        int c;
        do_reset();
        test_en = 1'b1; pp_sel = 2'd0; noise_en = 1'b0;
        repeat (50) @(negedge clk);
        chk(word_ready == 1'b0, "R5 no ready while disabled", 32'(word_ready), 32'h0);
        chk(rand_word == 32'h0, "R5 word untouched while disabled", rand_word, 32'h0);
        noise_en = 1'b1; noise_bit = 1'b1; noise_stb = 1'b1;
        wait_ready(100, c);
        chk(c == 32, "R8 ready after 32 cycles", 32'(c), 32'd32);
        model_word(2'd0, e);
        chk(rand_word == e, "R7 first generator word", rand_word, e);
        read_word();
        chk(word_ready == 1'b0, "R9 read clears ready", 32'(word_ready), 32'h0);
        wait_ready(100, c);
        chk(c == 32, "R8 second word timing", 32'(c), 32'd32);
        model_word(2'd0, e);
        chk(rand_word == e, "R6 noise ignored in test mode", rand_word, e);
        noise_stb = 1'b0; noise_bit = 1'b0;
    endtask

    // R2, R3, R4 per path
    task automatic t_mode(input logic [1:0] sel);
        logic [31:0] e;
        int c;
        do_reset();
        test_en = 1'b1; pp_sel = sel; noise_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_ready(2000, c);
            model_word(sel, e);
            chk(c > 0, $sformatf("R2 path %0d produces word", sel), 32'(c), 32'd1);
            chk(rand_word == e, $sformatf("R2 R3 R4 path %0d word %0d", sel, k), rand_word, e);
            read_word();
        end
    endtask

    // R10 hold behaviour in cascade path
    task automatic t_hold();
        logic [31:0] e, held;
        int c;
        bit stable;
        do_reset();
        test_en = 1'b1; pp_sel = 2'd3; noise_en = 1'b1;
        wait_ready(2000, c);
        model_word(2'd3, e);
        held = rand_word;
        chk(held == e, "R10 first cascaded word", held, e);
        stable = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rand_word != held || !word_ready) stable = 1'b0;
        end
        chk(stable, "R10 word held while unread", rand_word, held);
        read_word();
        wait_ready(2000, c);
        model_word(2'd3, e);
        chk(rand_word == e, "R10 sequence resumes after hold", rand_word, e);
    endtask

    // R6, R8, R9, R10 with live noise
    task automatic t_noise();
        logic [31:0] pat;
        int c;
        do_reset();
        test_en = 1'b0; pp_sel = 2'd0; noise_en = 1'b1;
        pat = 32'hF0A5_3C96;
        for (int i = 31; i >= 0; i--) begin
            push_bit(pat[i]);
            if (i == 22) begin
                read_word();
                chk(word_ready == 1'b0, "R9 read while filling ignored", 32'(word_ready), 32'h0);
            end
            @(negedge clk);
        end
        chk(word_ready == 1'b1, "R6 ready after 32 strobes", 32'(word_ready), 32'h1);
        chk(rand_word == pat, "R8 noise word bit order", rand_word, pat);
        for (int i = 0; i < 8; i++) push_bit(1'b1);
        chk(rand_word == pat, "R10 extra strobes dropped", rand_word, pat);
        read_word();
        pat = 32'h1234_5678;
        for (int i = 31; i >= 0; i--) push_bit(pat[i]);
        wait_ready(4, c);
        chk(rand_word == pat, "R10 next word has no stale bits", rand_word, pat);
        read_word();
        noise_en = 1'b0;
        for (int i = 0; i < 40; i++) push_bit(1'b1);
        chk(word_ready == 1'b0, "R5 strobes ignored when disabled", 32'(word_ready), 32'h0);
    endtask

    // R4 corrector on live noise with discarded pairs
    task automatic t_white_noise();
        logic [31:0] tgt;
        int c;
        do_reset();
        test_en = 1'b0; pp_sel = 2'd2; noise_en = 1'b1;
        tgt = 32'h9C3E_5A71;
        for (int i = 31; i >= 0; i--) begin
            if (i % 3 == 0) begin push_bit(1'b0); push_bit(1'b0); end
            if (i % 4 == 1) begin push_bit(1'b1); push_bit(1'b1); end
            push_bit(tgt[i]);
            push_bit(!tgt[i]);
        end
        wait_ready(4, c);
        chk(word_ready == 1'b1, "R4 corrector word complete", 32'(word_ready), 32'h1);
        chk(rand_word == tgt, "R4 corrector pair mapping", rand_word, tgt);
    endtask

    initial begin
        t_reset();
        t_test_raw();
        t_mode(2'd0);
        t_mode(2'd1);
        t_mode(2'd2);
        t_mode(2'd3);
        t_hold();
        t_noise();
        t_white_noise();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule